// File: doc/BRIEF.md
# NAND Program/Erase Command Sequencer

This block sits on the controller side of an 8-bit raw NAND flash bus and carries out two operations for a host: a multi-block erase and a write into the spare area of one page. The host raises a one-cycle request with an operation select, a byte address and a byte count. The sequencer then selects the device and emits the command, address and data bus cycles. It reads the device status until the device reports ready, and returns a two-bit result with a one-cycle acknowledge.

Completion and failure come from the status byte and not from a ready/busy pin. Every bus cycle lasts a fixed, parameterized number of clocks. The command or address strobe is held for the whole window, and the write or read strobe is low in its middle. Before an erase the sequencer reads status to check for write protection. It then walks the requested range one erase block at a time in ascending order. It asks a companion bad-block lookup about each block through `blk_addr_o`/`bad_blk_i`, and it skips any block flagged bad.

Top module: `nand_seq`

## Requirements
- R1: `nand_ce_no` is high while idle and in the acknowledge cycle. It is low during every bus cycle of an operation, and it is released on both normal and error exits.
- R2: A spare write (`op_i`=1) emits, in this order: command 0xFF, command 0x50, the full address, command 0x80, the full address again, then `len_i` data bytes taken from `wdata_i` (one per `wdata_take_o` pulse), command 0x10, command 0x70, and then status reads. The full address is the column byte `addr[7:0]` followed by the row bytes of `addr >> PAGE_SHIFT`, least significant first.
- R3: Each erased block emits command 0x60, the row bytes only with no column byte, command 0xD0, command 0x70, and then status reads.
- R4: Status reads repeat with no new command until a read returns bit 6 = 1. Bit 0 of a read with bit 6 = 0 has no effect on the result.
- R5: A ready status with bit 0 = 1 ends the operation with result 1 (fail). No further block is erased.
- R6: An erase first issues command 0x70 and one status read. If bit 7 = 0, the result is 2 (write protected) and no 0x60 command is issued.
- R7: An erase whose address or length is not a multiple of 2^BLK_SHIFT bytes gets result 3 (misaligned). No bus cycle is emitted and chip enable stays high.
- R8: An erase visits blocks in ascending address order, one erase block per step, until the length is used up. A block for which `bad_blk_i` is high while `blk_addr_o` holds its address is skipped with no bus cycles. A successful run, or a zero length, gives result 0.
- R9: Each bus cycle lasts CYC clocks. `nand_cle_o` (command) or `nand_ale_o` (address) is high for the whole window, and the two are never high together. The write or read strobe is low for CYC-2 clocks in its middle. `nand_dq_o` is stable while the write strobe is low, and the data bus is not driven during a read.
- R10: `ack_o` is a single-cycle pulse, and `result_o` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start request, sampled while idle |
| op_i | input | 1 | 0 = erase, 1 = spare-area write |
| addr_i | input | ADDR_W | Byte address |
| len_i | input | ADDR_W | Byte count |
| wdata_i | input | 8 | Spare data byte currently offered |
| wdata_take_o | output | 1 | Offered data byte is consumed this cycle |
| bad_blk_i | input | 1 | Block at `blk_addr_o` is bad |
| blk_addr_o | output | ADDR_W | Current working address |
| ack_o | output | 1 | Operation finished |
| result_o | output | 2 | 0 ok, 1 fail, 2 write protected, 3 misaligned |
| nand_ce_no | output | 1 | Chip enable, active low |
| nand_cle_o | output | 1 | Command latch strobe |
| nand_ale_o | output | 1 | Address latch strobe |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Bus data out |
| nand_dq_oe_o | output | 1 | Bus data output enable |
| nand_dq_i | input | 8 | Bus data in |

## Verification
The ready bit and the fail bit arrive in the same status byte, so ready detection and failure detection are decided in the same read. The bench device model answers with not-ready bytes that also carry bit 0 set, followed by a ready byte with bit 0 either clear or set. A correct design keeps polling through the first kind and must turn only the second kind into a fail result. The outcome is judged from the result code and from the exact bus-cycle log, which must show no extra command between polls and no erase of any later block after a failure.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  typedef enum logic [1:0] {BK_CMD, BK_ADDR, BK_DATA, BK_READ} bus_kind_e;
  typedef enum logic [1:0] {RES_OK = 2'd0, RES_FAIL = 2'd1, RES_WP = 2'd2, RES_MISALIGN = 2'd3} res_e;
endpackage

// File: rtl/nand_bus_cycle.sv
module nand_bus_cycle import nand_seq_pkg::*; #(
  parameter int CYC = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  bus_kind_e kind_i,
  input  logic [7:0] byte_i,
  output logic      busy_o,
  output logic      done_o,
  output logic [7:0] rdata_o,
  output logic      cle_o,
  output logic      ale_o,
  output logic      we_no,
  output logic      re_no,
  output logic [7:0] dq_o,
  output logic      dq_oe_o,
  input  logic [7:0] dq_i
);
  localparam int CW = (CYC > 2) ? $clog2(CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);
  localparam logic [CW-1:0] SAMP = CW'(CYC - 2);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  bus_kind_e     kind_q;
  logic [7:0]    byte_q;
  logic          mid;

  assign done_o = busy_q && (cnt_q == LAST);
  assign busy_o = busy_q;
  assign mid    = busy_q && (cnt_q != '0) && (cnt_q <= SAMP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      kind_q  <= BK_CMD;
      byte_q  <= '0;
      rdata_o <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        kind_q <= kind_i;
        byte_q <= byte_i;
      end
    end else begin
      if (done_o) busy_q <= 1'b0;
      else        cnt_q  <= cnt_q + 1'b1;
      if (kind_q == BK_READ && cnt_q == SAMP) rdata_o <= dq_i;
    end
  end

  assign cle_o   = busy_q && kind_q == BK_CMD;
  assign ale_o   = busy_q && kind_q == BK_ADDR;
  assign we_no   = !(mid && kind_q != BK_READ);
  assign re_no   = !(mid && kind_q == BK_READ);
  assign dq_oe_o = busy_q && kind_q != BK_READ;
  assign dq_o    = byte_q;
endmodule

// File: rtl/nand_blk_walker.sv
module nand_blk_walker #(
  parameter int ADDR_W    = 24,
  parameter int BLK_SHIFT = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              dec_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] len_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] len_o,
  output logic              misaligned_o
);
  localparam logic [ADDR_W-1:0] BLK = ADDR_W'(1) << BLK_SHIFT;

  assign misaligned_o = (|addr_i[BLK_SHIFT-1:0]) || (|len_i[BLK_SHIFT-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      len_o  <= '0;
    end else if (load_i) begin
      addr_o <= addr_i;
      len_o  <= len_i;
    end else if (step_i) begin
      addr_o <= addr_o + BLK;
      len_o  <= len_o - BLK;
    end else if (dec_i) begin
      len_o  <= len_o - 1'b1;
    end
  end
endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm import nand_seq_pkg::*; #(
  parameter int         ADDR_W     = 24,
  parameter int         PAGE_SHIFT = 9,
  parameter int         ROW_BYTES  = 2,
  parameter logic [7:0] OPC_RESET  = 8'hFF,
  parameter logic [7:0] OPC_SPARE  = 8'h50,
  parameter logic [7:0] OPC_SEQIN  = 8'h80,
  parameter logic [7:0] OPC_PROG   = 8'h10,
  parameter logic [7:0] OPC_ERASE1 = 8'h60,
  parameter logic [7:0] OPC_ERASE2 = 8'hD0,
  parameter logic [7:0] OPC_STATUS = 8'h70,
  parameter logic [7:0] MSK_RDY    = 8'h40,
  parameter logic [7:0] MSK_FAIL   = 8'h01,
  parameter logic [7:0] MSK_WPN    = 8'h80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              op_i,
  input  logic [7:0]        wdata_i,
  input  logic              bad_blk_i,
  input  logic              misaligned_i,
  input  logic [ADDR_W-1:0] cur_addr_i,
  input  logic [ADDR_W-1:0] cur_len_i,
  output logic              load_o,
  output logic              step_o,
  output logic              dec_o,
  output logic              wdata_take_o,
  output logic              ack_o,
  output res_e              result_o,
  output logic              ce_no,
  output logic              bus_start_o,
  output bus_kind_e         bus_kind_o,
  output logic [7:0]        bus_byte_o,
  input  logic              bus_busy_i,
  input  logic              bus_done_i,
  input  logic [7:0]        bus_rdata_i
);
  localparam int AW = $clog2(ROW_BYTES + 1);
  localparam int RW = 8 * ROW_BYTES;
  localparam logic [AW-1:0] A_LAST = AW'(ROW_BYTES);

  typedef enum logic [4:0] {
    S_IDLE, S_W_RST, S_W_PTR, S_W_A1, S_W_SEQ, S_W_A2, S_W_DAT, S_W_PROG,
    S_ST_CMD, S_ST_RD, S_WP_CMD, S_WP_RD, S_E_LOOP, S_E_C1, S_E_A, S_E_C2, S_DONE
  } st_e;

  st_e         st_q;
  logic [AW-1:0] aidx_q;
  logic        op_q;
  res_e        res_q;
  logic [RW-1:0] row;
  logic [7:0]  abyte;
  logic        need;
  logic        len_zero, rdy, fail, wp_n;

  assign row      = RW'(cur_addr_i >> PAGE_SHIFT);
  assign len_zero = (cur_len_i == '0);
  assign rdy      = |(bus_rdata_i & MSK_RDY);
  assign fail     = |(bus_rdata_i & MSK_FAIL);
  assign wp_n     = |(bus_rdata_i & MSK_WPN);

  always_comb begin
    abyte = cur_addr_i[7:0];
    for (int k = 0; k < ROW_BYTES; k++)
      if (aidx_q == AW'(k + 1)) abyte = row[8*k +: 8];
  end

  always_comb begin
    need       = 1'b1;
    bus_kind_o = BK_CMD;
    bus_byte_o = 8'h00;
    unique case (st_q)
      S_W_RST:                  bus_byte_o = OPC_RESET;
      S_W_PTR:                  bus_byte_o = OPC_SPARE;
      S_W_SEQ:                  bus_byte_o = OPC_SEQIN;
      S_W_PROG:                 bus_byte_o = OPC_PROG;
      S_ST_CMD, S_WP_CMD:       bus_byte_o = OPC_STATUS;
      S_E_C1:                   bus_byte_o = OPC_ERASE1;
      S_E_C2:                   bus_byte_o = OPC_ERASE2;
      S_W_A1, S_W_A2, S_E_A: begin bus_kind_o = BK_ADDR; bus_byte_o = abyte; end
      S_W_DAT: begin bus_kind_o = BK_DATA; bus_byte_o = wdata_i; end
      S_ST_RD, S_WP_RD:         bus_kind_o = BK_READ;
      default:                  need = 1'b0;
    endcase
  end

  assign bus_start_o  = need && !bus_busy_i;
  assign wdata_take_o = bus_start_o && st_q == S_W_DAT;
  assign load_o       = st_q == S_IDLE && req_i;
  assign dec_o        = st_q == S_W_DAT && bus_done_i;
  assign step_o       = (st_q == S_E_LOOP && !len_zero && bad_blk_i) ||
                        (st_q == S_ST_RD && bus_done_i && rdy && !fail && !op_q);
  assign ack_o        = st_q == S_DONE;
  assign result_o     = res_q;
  assign ce_no        = st_q == S_IDLE || st_q == S_DONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      aidx_q <= '0;
      op_q   <= 1'b0;
      res_q  <= RES_OK;
    end else begin
      unique case (st_q)
        S_IDLE: if (req_i) begin
          op_q   <= op_i;
          aidx_q <= '0;
          if (op_i) st_q <= S_W_RST;
          else if (misaligned_i) begin res_q <= RES_MISALIGN; st_q <= S_DONE; end
          else st_q <= S_WP_CMD;
        end
        S_W_RST:  if (bus_done_i) st_q <= S_W_PTR;
        S_W_PTR:  if (bus_done_i) st_q <= S_W_A1;
        S_W_A1:   if (bus_done_i) begin
          if (aidx_q == A_LAST) begin aidx_q <= '0; st_q <= S_W_SEQ; end
          else aidx_q <= aidx_q + 1'b1;
        end
        S_W_SEQ:  if (bus_done_i) st_q <= S_W_A2;
        S_W_A2:   if (bus_done_i) begin
          if (aidx_q == A_LAST) st_q <= len_zero ? S_W_PROG : S_W_DAT;
          else aidx_q <= aidx_q + 1'b1;
        end
        S_W_DAT:  if (bus_done_i && cur_len_i == ADDR_W'(1)) st_q <= S_W_PROG;
        S_W_PROG: if (bus_done_i) st_q <= S_ST_CMD;
        S_ST_CMD: if (bus_done_i) st_q <= S_ST_RD;
        S_ST_RD:  if (bus_done_i && rdy) begin
          if (fail) begin res_q <= RES_FAIL; st_q <= S_DONE; end
          else if (op_q) begin res_q <= RES_OK; st_q <= S_DONE; end
          else st_q <= S_E_LOOP;
        end
        S_WP_CMD: if (bus_done_i) st_q <= S_WP_RD;
        S_WP_RD:  if (bus_done_i) begin
          if (!wp_n) begin res_q <= RES_WP; st_q <= S_DONE; end
          else st_q <= S_E_LOOP;
        end
        S_E_LOOP: begin
          if (len_zero) begin res_q <= RES_OK; st_q <= S_DONE; end
          else if (!bad_blk_i) begin aidx_q <= AW'(1); st_q <= S_E_C1; end
        end
        S_E_C1:   if (bus_done_i) st_q <= S_E_A;
        S_E_A:    if (bus_done_i) begin
          if (aidx_q == A_LAST) st_q <= S_E_C2;
          else aidx_q <= aidx_q + 1'b1;
        end
        S_E_C2:   if (bus_done_i) st_q <= S_ST_CMD;
        default:  st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_seq.sv
module nand_seq import nand_seq_pkg::*; #(
  parameter int         ADDR_W     = 24,
  parameter int         PAGE_SHIFT = 9,
  parameter int         BLK_SHIFT  = 13,
  parameter int         ROW_BYTES  = 2,
  parameter int         CYC        = 4,
  parameter logic [7:0] OPC_RESET  = 8'hFF,
  parameter logic [7:0] OPC_SPARE  = 8'h50,
  parameter logic [7:0] OPC_SEQIN  = 8'h80,
  parameter logic [7:0] OPC_PROG   = 8'h10,
  parameter logic [7:0] OPC_ERASE1 = 8'h60,
  parameter logic [7:0] OPC_ERASE2 = 8'hD0,
  parameter logic [7:0] OPC_STATUS = 8'h70
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] len_i,
  input  logic [7:0]        wdata_i,
  output logic              wdata_take_o,
  input  logic              bad_blk_i,
  output logic [ADDR_W-1:0] blk_addr_o,
  output logic              ack_o,
  output logic [1:0]        result_o,
  output logic              nand_ce_no,
  output logic              nand_cle_o,
  output logic              nand_ale_o,
  output logic              nand_we_no,
  output logic              nand_re_no,
  output logic [7:0]        nand_dq_o,
  output logic              nand_dq_oe_o,
  input  logic [7:0]        nand_dq_i
);
  logic              load, step, dec, misaligned;
  logic [ADDR_W-1:0] cur_len;
  logic              bus_start, bus_busy, bus_done;
  bus_kind_e         bus_kind;
  logic [7:0]        bus_byte, bus_rdata;
  res_e              res;

  assign result_o = res;

  nand_blk_walker #(.ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT)) u_walk (
    .clk_i, .rst_ni, .load_i(load), .step_i(step), .dec_i(dec),
    .addr_i, .len_i, .addr_o(blk_addr_o), .len_o(cur_len), .misaligned_o(misaligned)
  );

  nand_seq_fsm #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .ROW_BYTES(ROW_BYTES),
    .OPC_RESET(OPC_RESET), .OPC_SPARE(OPC_SPARE), .OPC_SEQIN(OPC_SEQIN), .OPC_PROG(OPC_PROG),
    .OPC_ERASE1(OPC_ERASE1), .OPC_ERASE2(OPC_ERASE2), .OPC_STATUS(OPC_STATUS)
  ) u_fsm (
    .clk_i, .rst_ni, .req_i, .op_i, .wdata_i, .bad_blk_i,
    .misaligned_i(misaligned), .cur_addr_i(blk_addr_o), .cur_len_i(cur_len),
    .load_o(load), .step_o(step), .dec_o(dec), .wdata_take_o, .ack_o,
    .result_o(res), .ce_no(nand_ce_no),
    .bus_start_o(bus_start), .bus_kind_o(bus_kind), .bus_byte_o(bus_byte),
    .bus_busy_i(bus_busy), .bus_done_i(bus_done), .bus_rdata_i(bus_rdata)
  );

  nand_bus_cycle #(.CYC(CYC)) u_bus (
    .clk_i, .rst_ni, .start_i(bus_start), .kind_i(bus_kind), .byte_i(bus_byte),
    .busy_o(bus_busy), .done_o(bus_done), .rdata_o(bus_rdata),
    .cle_o(nand_cle_o), .ale_o(nand_ale_o), .we_no(nand_we_no), .re_no(nand_re_no),
    .dq_o(nand_dq_o), .dq_oe_o(nand_dq_oe_o), .dq_i(nand_dq_i)
  );
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ack_o,
  input logic       nand_ce_no,
  input logic       nand_cle_o,
  input logic       nand_ale_o,
  input logic       nand_we_no,
  input logic       nand_re_no,
  input logic [7:0] nand_dq_o,
  input logic       nand_dq_oe_o
);
  a_r1_ce_with_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nand_we_no || !nand_re_no) |-> !nand_ce_no);
  a_r1_ce_off_at_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> nand_ce_no);
  a_r9_latch_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nand_cle_o && nand_ale_o));
  a_r9_dq_stable_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nand_we_no && !$past(nand_we_no)) |-> $stable(nand_dq_o));
  a_r9_no_drive_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_re_no |-> !nand_dq_oe_o);
  a_r10_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
endmodule

bind nand_seq nand_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_o(ack_o), .nand_ce_no(nand_ce_no),
  .nand_cle_o(nand_cle_o), .nand_ale_o(nand_ale_o), .nand_we_no(nand_we_no),
  .nand_re_no(nand_re_no), .nand_dq_o(nand_dq_o), .nand_dq_oe_o(nand_dq_oe_o)
);

// File: tb/nand_seq_tb.sv
module nand_seq_tb;
  localparam int AW = 24;
  localparam int CYC = 4;
  localparam int BLK_SHIFT = 13;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, req, op, take, bad, ack, ce_n, cle, ale, we_n, re_n, oe;
  logic [AW-1:0] addr, len, blk_addr;
  logic [7:0] wdata, dq_o, dq_i;
  logic [1:0] result;
  logic [31:0] bad_mask;

  assign bad = bad_mask[blk_addr[BLK_SHIFT +: 5]];

  nand_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .addr_i(addr), .len_i(len),
    .wdata_i(wdata), .wdata_take_o(take), .bad_blk_i(bad), .blk_addr_o(blk_addr),
    .ack_o(ack), .result_o(result), .nand_ce_no(ce_n), .nand_cle_o(cle), .nand_ale_o(ale),
    .nand_we_no(we_n), .nand_re_no(re_n), .nand_dq_o(dq_o), .nand_dq_oe_o(oe), .nand_dq_i(dq_i)
  );

  int errors = 0, checks = 0;
  int log_q[$], exp_q[$];
  logic [7:0] st_q[$], wbuf[$];
  int widx = 0;
  int we_w = 0;
  bit prev_we = 1'b1, prev_re = 1'b1, prev_cle = 1'b0, prev_ale = 1'b0;
  logic [7:0] prev_dq = 8'h00;
  bit ce_seen = 1'b0, in_op = 1'b0;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // bus device model and per-clock protocol checks
  always @(negedge clk) begin
    wdata = (widx < wbuf.size()) ? wbuf[widx] : 8'h00;
    if (take) widx++;
    dq_i = (!re_n && st_q.size() > 0) ? st_q[0] : 8'hC0;
    if (rst_n) begin
      if (!ce_n) ce_seen = 1'b1;
      if (!we_n || !re_n) chk(!ce_n, "R1 ce with strobe", ce_n, 0);
      if (!in_op) chk(ce_n, "R1 ce idle", ce_n, 1);
      chk(!(cle && ale), "R9 cle/ale exclusive", {cle, ale}, 0);
      if (!we_n) we_w++;
      if (!we_n && !prev_we) chk(dq_o == prev_dq, "R9 dq stable", dq_o, prev_dq);
      if (we_n && !prev_we) begin
        chk(we_w == CYC - 2, "R9 we width", we_w, CYC - 2);
        log_q.push_back((prev_cle ? 1 : prev_ale ? 2 : 3) * 256 + prev_dq);
        we_w = 0;
      end
      if (!re_n) chk(!oe, "R9 no drive on read", oe, 0);
      if (re_n && !prev_re) begin
        log_q.push_back(4 * 256 + (st_q.size() > 0 ? st_q[0] : 8'hC0));
        if (st_q.size() > 0) void'(st_q.pop_front());
      end
    end
    prev_we = we_n; prev_re = re_n; prev_cle = cle; prev_ale = ale; prev_dq = dq_o;
  end

  task automatic e_cmd(input logic [7:0] b); exp_q.push_back(256 + b); endtask
  task automatic e_row(input logic [AW-1:0] a);
    logic [AW-1:0] r;
    r = a >> 9;
    exp_q.push_back(512 + r[7:0]);
    exp_q.push_back(512 + r[15:8]);
  endtask
  task automatic e_full(input logic [AW-1:0] a); exp_q.push_back(512 + a[7:0]); e_row(a); endtask
  task automatic e_dat(input logic [7:0] b); exp_q.push_back(768 + b); endtask
  task automatic e_rd(input logic [7:0] b); exp_q.push_back(1024 + b); endtask

  task automatic run_op(input bit o, input logic [AW-1:0] a, input logic [AW-1:0] l, output logic [1:0] res);
    int n;
    @(negedge clk);
    log_q.delete(); widx = 0; ce_seen = 1'b0; in_op = 1'b1;
    op = o; addr = a; len = l; req = 1'b1;
    @(negedge clk);
    req = 1'b0; n = 0;
    while (!ack && n < 3000) begin @(negedge clk); n++; end
    if (!ack) chk(0, "watchdog", n, 0);
    res = result;
    chk(ce_n, "R1 ce released at ack", ce_n, 1);
    @(negedge clk);
    in_op = 1'b0;
    chk(!ack, "R10 ack single cycle", ack, 0);
  endtask

  task automatic cmp_log(input string r);
    int bad_i;
    bad_i = -1;
    chk(log_q.size() == exp_q.size(), {r, " log length"}, log_q.size(), exp_q.size());
    foreach (exp_q[i]) if (bad_i < 0 && (i >= log_q.size() || log_q[i] != exp_q[i])) bad_i = i;
    if (bad_i >= 0) chk(0, {r, " log content"}, (bad_i < log_q.size()) ? log_q[bad_i] : -1, exp_q[bad_i]);
    else chk(1, r, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [1:0] res;
    rst_n = 1'b0; req = 1'b0; op = 1'b0; addr = '0; len = '0; bad_mask = '0;
    repeat (3) @(negedge clk);
    chk(ce_n && we_n && re_n && !cle && !ale, "R1 reset bus idle", {ce_n, we_n, re_n, cle, ale}, 5'b11100);
    chk(!ack, "R10 reset no ack", ack, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R4: spare write with busy polls carrying bit0
    wbuf = '{8'hAA, 8'h55, 8'h3C};
    st_q = '{8'h81, 8'h81, 8'hC0};
    exp_q.delete();
    e_cmd(8'hFF); e_cmd(8'h50); e_full(24'h002A05); e_cmd(8'h80); e_full(24'h002A05);
    e_dat(8'hAA); e_dat(8'h55); e_dat(8'h3C); e_cmd(8'h10); e_cmd(8'h70);
    e_rd(8'h81); e_rd(8'h81); e_rd(8'hC0);
    run_op(1'b1, 24'h002A05, 24'd3, res);
    chk(res == 2'd0, "R4 busy bit0 ignored result", res, 0);
    cmp_log("R2 spare write order");

    // R5: spare write fail
    wbuf = '{8'h19};
    st_q = '{8'hC1};
    exp_q.delete();
    e_cmd(8'hFF); e_cmd(8'h50); e_full(24'h000610); e_cmd(8'h80); e_full(24'h000610);
    e_dat(8'h19); e_cmd(8'h10); e_cmd(8'h70); e_rd(8'hC1);
    run_op(1'b1, 24'h000610, 24'd1, res);
    chk(res == 2'd1, "R5 spare fail result", res, 1);
    cmp_log("R5 spare fail log");

    // R7: misaligned address, then misaligned length
    exp_q.delete(); st_q.delete();
    run_op(1'b0, 24'h000100, 24'h002000, res);
    chk(res == 2'd3, "R7 misaligned addr", res, 3);
    chk(!ce_seen, "R7 ce stays high", ce_seen, 0);
    cmp_log("R7 no bus cycles");
    run_op(1'b0, 24'h002000, 24'h000100, res);
    chk(res == 2'd3, "R7 misaligned len", res, 3);
    cmp_log("R7 no bus cycles len");

    // R6: write protected
    st_q = '{8'h40};
    exp_q.delete(); e_cmd(8'h70); e_rd(8'h40);
    run_op(1'b0, 24'h004000, 24'h004000, res);
    chk(res == 2'd2, "R6 write protected", res, 2);
    cmp_log("R6 no erase issued");

    // R3 R8: three blocks, middle one bad
    bad_mask = 32'h0000_0008;
    st_q = '{8'h80, 8'h81, 8'hC0, 8'hC0};
    exp_q.delete();
    e_cmd(8'h70); e_rd(8'h80);
    e_cmd(8'h60); e_row(24'h004000); e_cmd(8'hD0); e_cmd(8'h70); e_rd(8'h81); e_rd(8'hC0);
    e_cmd(8'h60); e_row(24'h008000); e_cmd(8'hD0); e_cmd(8'h70); e_rd(8'hC0);
    run_op(1'b0, 24'h004000, 24'h006000, res);
    chk(res == 2'd0, "R8 erase ok", res, 0);
    cmp_log("R3 R8 erase walk with skip");
    bad_mask = '0;

    // R5: fail on first of two blocks aborts the rest
    st_q = '{8'h80, 8'hC1};
    exp_q.delete();
    e_cmd(8'h70); e_rd(8'h80); e_cmd(8'h60); e_row(24'h000000); e_cmd(8'hD0); e_cmd(8'h70); e_rd(8'hC1);
    run_op(1'b0, 24'h000000, 24'h004000, res);
    chk(res == 2'd1, "R5 erase fail", res, 1);
    cmp_log("R5 abort remaining blocks");

    // R8: zero length erase
    st_q = '{8'h80};
    exp_q.delete(); e_cmd(8'h70); e_rd(8'h80);
    run_op(1'b0, 24'h00A000, 24'h000000, res);
    chk(res == 2'd0, "R8 zero length ok", res, 0);
    cmp_log("R8 zero length log");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule